// File: doc/BRIEF.md
# Flash Write-Protection and Enable Latch

This block is the gatekeeper that decides whether a data-modifying instruction in a serial NOR flash is allowed to start. The serial front end decodes an instruction and presents it once, when chip select rises. It supplies the opcode, the number of serial clocks counted while the device was selected, the byte address and the status byte carried by a status write. The block answers one cycle later with a single-cycle execute permit. The array sequencer runs a permitted operation and reports its end with a completion strobe.

The block holds the write-enable latch, the three block-protect bits, the status-write-disable bit and a busy flag. It also samples the active-low write-protect pin. A program or sector erase is refused when its target sector lies in the region the protect bits reserve. That region is counted down from the top sector. A bulk erase is refused unless no sector is protected. A status write is refused while the disable bit is set and the pin is held low. These bits are packed into a status byte for status reads.

Top module: `flash_wprot_ctrl`

## Requirements
- R1: After reset the enable latch, the protect bits, the disable bit and busy are 0, so the status byte reads 0x00, and exec_permit is low.
- R2: Opcode 0x06 sets the enable latch and 0x04 clears it. Both take effect in the cycle after cmd_valid, whatever the clock count.
- R3: A status write (0x01), page program (0x02), sector erase (0xD8) or bulk erase (0xC7) whose clock count has nonzero bits [2:0] gets no permit and changes no state.
- R4: A modifying instruction gets no permit while the enable latch is 0.
- R5: The sector index is address bits [19:16] of the 16 sectors. A protect code of 0 protects none. Code 1 protects sector 15, code 2 sectors 14–15, code 3 sectors 12–15 and code 4 sectors 8–15. Codes 5, 6 and 7 protect all sectors. A page program or sector erase to a protected sector gets no permit.
- R6: A bulk erase gets a permit only when the protect code is 0.
- R7: While the disable bit is 1 and wp_n is 0, a status write gets no permit. With wp_n high it is allowed.
- R8: A refused instruction leaves the enable latch unchanged. A permitted operation keeps the latch set until its completion strobe, after which the latch reads 0.
- R9: A permitted status write updates the status only at its completion. The protect code is taken from data bits [4:2] and the disable bit from data bit [7].
- R10: exec_permit pulses in the cycle after cmd_valid. Busy (status bit 0) is then 1 until op_done. While busy, every modifying instruction is refused.
- R11: Same cycle: when 0x06 arrives together with op_done, the latch ends at 1 and busy at 0. A modifying instruction that arrives together with op_done is refused.
- R12: Other opcodes, and op_done while not busy, change nothing.
- R13: The status byte is {disable, 0, 0, protect[2:0], latch, busy}, from bit 7 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe: instruction ended at chip-select rise |
| cmd_opcode | input | 8 | Decoded opcode |
| cmd_clk_count | input | 16 | Serial clocks counted while selected |
| cmd_addr | input | 20 | Target byte address |
| cmd_sr_data | input | 8 | Status byte carried by a status write |
| wp_n | input | 1 | Write-protect pin, active low |
| op_done | input | 1 | Completion strobe from the array sequencer |
| exec_permit | output | 1 | One-cycle permit to start the operation |
| st_wel | output | 1 | Write-enable latch |
| st_bp | output | 3 | Block-protect code |
| st_srwd | output | 1 | Status-write-disable bit |
| st_busy | output | 1 | Operation in progress |
| st_status | output | 8 | Packed status byte |

## Verification
The enable latch can be set by a write-enable instruction and cleared by a completion strobe in the same cycle. In that case the latch must end set and busy must end clear. A modifying instruction can also arrive in the very cycle its predecessor completes. It must be refused, because the permit decision sees the busy flag before the completion takes effect. The bench provokes both collisions by driving cmd_valid and op_done in one cycle. It then reads exec_permit and the status byte on the next cycle.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;
  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_WRDI = 8'h04;
  localparam logic [7:0] OPC_WRSR = 8'h01;
  localparam logic [7:0] OPC_PP   = 8'h02;
  localparam logic [7:0] OPC_SE   = 8'hD8;
  localparam logic [7:0] OPC_BE   = 8'hC7;

  typedef enum logic [2:0] {
    K_NONE, K_WREN, K_WRDI, K_WRSR, K_PP, K_SE, K_BE
  } op_kind_e;
endpackage

// File: rtl/flash_wp_decode.sv
module flash_wp_decode
  import flash_wp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [7:0]       opcode,
  input  logic [CNT_W-1:0] clk_count,
  output op_kind_e         kind,
  output logic             is_modify,
  output logic             frame_ok
);
  always_comb begin
    unique case (opcode)
      OPC_WREN: kind = K_WREN;
      OPC_WRDI: kind = K_WRDI;
      OPC_WRSR: kind = K_WRSR;
      OPC_PP:   kind = K_PP;
      OPC_SE:   kind = K_SE;
      OPC_BE:   kind = K_BE;
      default:  kind = K_NONE;
    endcase
  end

  assign is_modify = (kind == K_WRSR) || (kind == K_PP) ||
                     (kind == K_SE) || (kind == K_BE);
  assign frame_ok  = (clk_count[2:0] == 3'b000);
endmodule

// File: rtl/flash_wp_sector_map.sv
module flash_wp_sector_map #(
  parameter int SECT_BITS = 4
) (
  input  logic [2:0]           bp,
  input  logic [SECT_BITS-1:0] sector,
  output logic                 sect_prot,
  output logic                 none_prot
);
  localparam int NSECT = 1 << SECT_BITS;
  localparam logic [SECT_BITS:0] NSECT_V = NSECT[SECT_BITS:0];
  localparam logic [SECT_BITS:0] ONE_V   = {{SECT_BITS{1'b0}}, 1'b1};

  logic [SECT_BITS:0] low_sect;

  always_comb begin
    if (bp == 3'd0)
      low_sect = NSECT_V;
    else if (int'(bp) > SECT_BITS)
      low_sect = '0;
    else
      low_sect = NSECT_V - (ONE_V << (bp - 3'd1));
  end

  assign sect_prot = ({1'b0, sector} >= low_sect);
  assign none_prot = (bp == 3'd0);
endmodule

// File: rtl/flash_wp_state.sv
module flash_wp_state
  import flash_wp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  op_kind_e   kind,
  input  logic       accept,
  input  logic [7:0] sr_data,
  input  logic       op_done,
  output logic       wel,
  output logic [2:0] bp,
  output logic       srwd,
  output logic       busy
);
  logic       pend_wrsr;
  logic [2:0] pend_bp;
  logic       pend_srwd;
  logic       done_eff;

  assign done_eff = op_done && busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      wel       <= 1'b0;
      bp        <= '0;
      srwd      <= 1'b0;
      busy      <= 1'b0;
      pend_wrsr <= 1'b0;
      pend_bp   <= '0;
      pend_srwd <= 1'b0;
    end else begin
      if (accept)        busy <= 1'b1;
      else if (done_eff) busy <= 1'b0;

      if (cmd_valid && kind == K_WREN)
        wel <= 1'b1;
      else if ((cmd_valid && kind == K_WRDI) || done_eff)
        wel <= 1'b0;

      if (accept) begin
        pend_wrsr <= (kind == K_WRSR);
        pend_bp   <= sr_data[4:2];
        pend_srwd <= sr_data[7];
      end else if (done_eff) begin
        pend_wrsr <= 1'b0;
        if (pend_wrsr) begin
          bp   <= pend_bp;
          srwd <= pend_srwd;
        end
      end
    end
  end

  a_r8_done_clears_wel: assert property (@(posedge clk) disable iff (rst)
    (busy && op_done && !(cmd_valid && kind == K_WREN)) |=> !wel);
  a_r10_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && !op_done) |=> busy);
  a_r9_status_at_done: assert property (@(posedge clk) disable iff (rst)
    !(busy && op_done) |=> ($stable(bp) && $stable(srwd)));
  a_r11_wren_wins: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && kind == K_WREN) |=> wel);
endmodule

// File: rtl/flash_wprot_ctrl.sv
module flash_wprot_ctrl
  import flash_wp_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int SECT_BITS = 4,
  parameter int CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_opcode,
  input  logic [CNT_W-1:0]  cmd_clk_count,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_sr_data,
  input  logic              wp_n,
  input  logic              op_done,
  output logic              exec_permit,
  output logic              st_wel,
  output logic [2:0]        st_bp,
  output logic              st_srwd,
  output logic              st_busy,
  output logic [7:0]        st_status
);
  op_kind_e kind;
  logic     is_modify, frame_ok;
  logic     sect_prot, none_prot;
  logic     hw_lock, target_ok, permit_c;

  flash_wp_decode #(.CNT_W(CNT_W)) u_dec (
    .opcode    (cmd_opcode),
    .clk_count (cmd_clk_count),
    .kind      (kind),
    .is_modify (is_modify),
    .frame_ok  (frame_ok)
  );

  flash_wp_sector_map #(.SECT_BITS(SECT_BITS)) u_map (
    .bp        (st_bp),
    .sector    (cmd_addr[ADDR_W-1 -: SECT_BITS]),
    .sect_prot (sect_prot),
    .none_prot (none_prot)
  );

  assign hw_lock = st_srwd && !wp_n;

  always_comb begin
    unique case (kind)
      K_WRSR:      target_ok = !hw_lock;
      K_PP, K_SE:  target_ok = !sect_prot;
      K_BE:        target_ok = none_prot;
      default:     target_ok = 1'b0;
    endcase
  end

  assign permit_c = cmd_valid && is_modify && frame_ok && st_wel &&
                    !st_busy && target_ok;

  flash_wp_state u_st (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .kind      (kind),
    .accept    (permit_c),
    .sr_data   (cmd_sr_data),
    .op_done   (op_done),
    .wel       (st_wel),
    .bp        (st_bp),
    .srwd      (st_srwd),
    .busy      (st_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) exec_permit <= 1'b0;
    else     exec_permit <= permit_c;
  end

  assign st_status = {st_srwd, 2'b00, st_bp, st_wel, st_busy};

  a_r4_needs_wel: assert property (@(posedge clk) disable iff (rst)
    exec_permit |-> $past(st_wel));
  a_r3_whole_bytes: assert property (@(posedge clk) disable iff (rst)
    exec_permit |-> ($past(cmd_clk_count[2:0]) == 3'b000));
  a_r6_bulk_unprotected: assert property (@(posedge clk) disable iff (rst)
    (exec_permit && $past(cmd_opcode) == OPC_BE) |-> ($past(st_bp) == 3'd0));
  a_r7_hw_lock: assert property (@(posedge clk) disable iff (rst)
    (exec_permit && $past(cmd_opcode) == OPC_WRSR) |-> !$past(st_srwd && !wp_n));
  a_r10_not_while_busy: assert property (@(posedge clk) disable iff (rst)
    exec_permit |-> !$past(st_busy));
  a_r10_permit_sets_busy: assert property (@(posedge clk) disable iff (rst)
    exec_permit |-> st_busy);
endmodule

// File: tb/flash_wprot_ctrl_tb_top.sv
module flash_wprot_ctrl_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic [7:0]  cmd_opcode;
  logic [15:0] cmd_clk_count;
  logic [19:0] cmd_addr;
  logic [7:0]  cmd_sr_data;
  logic        wp_n;
  logic        op_done;
  logic        exec_permit, st_wel, st_srwd, st_busy;
  logic [2:0]  st_bp;
  logic [7:0]  st_status;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  flash_wprot_ctrl dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
    .cmd_clk_count(cmd_clk_count), .cmd_addr(cmd_addr), .cmd_sr_data(cmd_sr_data),
    .wp_n(wp_n), .op_done(op_done), .exec_permit(exec_permit), .st_wel(st_wel),
    .st_bp(st_bp), .st_srwd(st_srwd), .st_busy(st_busy), .st_status(st_status)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // drive one cycle at negedge, sample results at the following negedge
  task automatic step(input logic v, input logic [7:0] op, input int cnt,
                      input logic [19:0] addr, input logic [7:0] data,
                      input logic done);
    cmd_valid = v; cmd_opcode = op; cmd_clk_count = cnt[15:0];
    cmd_addr = addr; cmd_sr_data = data; op_done = done;
    @(negedge clk);
    cmd_valid = 1'b0; op_done = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] op, input int cnt, input logic [19:0] addr,
                     input logic [7:0] data);
    step(1'b1, op, cnt, addr, data, 1'b0);
  endtask

  task automatic done();
    step(1'b0, 8'h00, 0, '0, 8'h00, 1'b1);
  endtask

  task automatic set_status(input logic [7:0] data);
    cmd(8'h06, 8, '0, 0);
    cmd(8'h01, 16, '0, data);
    done();
  endtask

  function automatic int low_sector(input int code);
    case (code)
      0: return 16;
      1: return 15;
      2: return 14;
      3: return 12;
      4: return 8;
      default: return 0;
    endcase
  endfunction

  task automatic t_reset();
    chk("R1 status", st_status, 8'h00);
    chk("R1 permit", exec_permit, 0);
  endtask

  task automatic t_latch();
    cmd(8'h06, 13, '0, 0);
    chk("R2 wren odd count", st_wel, 1);
    chk("R13 status wel bit", st_status, 8'h02);
    cmd(8'h04, 8, '0, 0);
    chk("R2 wrdi", st_wel, 0);
  endtask

  task automatic t_frame();
    cmd(8'h06, 8, '0, 0);
    cmd(8'h02, 37, 20'h10000, 0);
    chk("R3 pp bad count permit", exec_permit, 0);
    chk("R8 latch kept after refusal", st_status, 8'h02);
    cmd(8'h01, 15, '0, 8'h9C);
    chk("R3 wrsr bad count permit", exec_permit, 0);
    done();
    chk("R3 no status change", st_status, 8'h02);
  endtask

  task automatic t_wel_needed();
    cmd(8'h04, 8, '0, 0);
    cmd(8'h02, 32, 20'h30000, 0);
    chk("R4 pp without latch", exec_permit, 0);
    cmd(8'hC7, 8, '0, 0);
    chk("R4 be without latch", exec_permit, 0);
  endtask

  task automatic t_program();
    cmd(8'h06, 8, '0, 0);
    cmd(8'h02, 40, 20'h3_1234, 0);
    chk("R10 pp permit", exec_permit, 1);
    chk("R10 busy and latch", st_status, 8'h03);
    @(negedge clk);
    chk("R10 permit single cycle", exec_permit, 0);
    cmd(8'hD8, 32, 20'h2_0000, 0);
    chk("R10 refused while busy", exec_permit, 0);
    done();
    chk("R8 latch clear at done", st_status, 8'h00);
  endtask

  task automatic t_map();
    for (int code = 0; code < 8; code++) begin
      set_status(8'(code << 2));
      chk("R9 protect code committed", st_bp, code);
      for (int s = 0; s < 16; s++) begin
        cmd(8'h06, 8, '0, 0);
        cmd(8'hD8, 32, 20'(s << 16), 0);
        chk($sformatf("R5 code %0d sector %0d", code, s), exec_permit,
            (s < low_sector(code)) ? 1 : 0);
        if (exec_permit) done();
        else chk("R8 latch kept on protected", st_wel, 1);
        cmd(8'h04, 8, '0, 0);
      end
      cmd(8'h06, 8, '0, 0);
      cmd(8'hC7, 8, '0, 0);
      chk($sformatf("R6 bulk code %0d", code), exec_permit, (code == 0) ? 1 : 0);
      if (exec_permit) done();
      cmd(8'h04, 8, '0, 0);
    end
    set_status(8'h00);
  endtask

  task automatic t_hwlock();
    set_status(8'h84);
    chk("R9 disable and code", st_status, 8'h84);
    wp_n = 1'b0;
    cmd(8'h06, 8, '0, 0);
    cmd(8'h01, 16, '0, 8'h00);
    chk("R7 locked write refused", exec_permit, 0);
    chk("R7 locked status kept", st_status, 8'h86);
    wp_n = 1'b1;
    cmd(8'h01, 16, '0, 8'h00);
    chk("R7 unlocked write allowed", exec_permit, 1);
    chk("R9 status before done", st_bp, 1);
    done();
    chk("R9 status after done", st_status, 8'h00);
  endtask

  task automatic t_collide();
    cmd(8'h06, 8, '0, 0);
    cmd(8'h02, 8, 20'h0_0100, 0);
    step(1'b1, 8'h06, 8, '0, 0, 1'b1);
    chk("R11 wren with done", st_status, 8'h02);
    cmd(8'h02, 8, 20'h0_0200, 0);
    chk("R11 setup permit", exec_permit, 1);
    step(1'b1, 8'hD8, 8, 20'h1_0000, 0, 1'b1);
    chk("R11 cmd with done permit", exec_permit, 0);
    chk("R11 cmd with done status", st_status, 8'h00);
  endtask

  task automatic t_ignore();
    cmd(8'h06, 8, '0, 0);
    cmd(8'h03, 32, '0, 8'hFF);
    chk("R12 unknown permit", exec_permit, 0);
    cmd(8'hAB, 32, '0, 8'hFF);
    done();
    chk("R12 unknown and idle done", st_status, 8'h02);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; wp_n = 1'b1; cmd_valid = 1'b0; op_done = 1'b0;
    cmd_opcode = '0; cmd_clk_count = '0; cmd_addr = '0; cmd_sr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_latch();
    t_frame();
    t_wel_needed();
    t_program();
    t_map();
    t_hwlock();
    t_collide();
    t_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule